// File: doc/BRIEF.md
# DSP ALU Condition Flag Unit

This block is the flag and status stage of a fixed-point DSP arithmetic unit whose accumulators hold 8 guard bits above a 32-bit word, 40 bits in all. Each cycle that `op_valid` is high it takes two 40-bit source operands and an operation code. It forms the exact arithmetic result and registers a 40-bit result, which may be saturated. It also registers four status bits: negative, zero, 32-bit overflow and signed greater-than. A single condition bit, DC, holds whichever condition the 3-bit condition-select input names.

The signed greater-than and greater-or-equal conditions do not trust the stored sign bit alone. When the exact result does not fit in 40 signed bits (over-range), the stored bit 39 shows the wrong sign. The block therefore corrects the sign with the over-range term, so both conditions agree with a true signed comparison of the operands. The add-with-carry and subtract-with-borrow operations take the registered DC as their carry input. They write their carry or borrow back into DC whatever condition-select holds, which lets multi-word arithmetic be chained.

The unit has no state machine. Its only sequential state is the result register and the flag register, and both load on a valid operation edge. Operations are decoded through an enumerated operation type and condition-select through an enumerated selector type, each resolved in a unique case.

Top module: `dsp_flag_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears `result`, `dc_flag`, `n_flag`, `z_flag`, `v_flag` and `gt_flag` to zero.
- R2: With `op_valid` high, operation codes 3'b000 (add), 3'b001 (subtract), 3'b011 (add-with-carry) and 3'b100 (subtract-with-borrow) register `result` as the low 40 bits of src1+src2, src1-src2, src1+src2+DC and src1-src2-DC respectively. Code 3'b010 (compare) computes src1-src2 for the flags only and leaves `result` unchanged.
- R3: After a compare with condition-select 3'b100, `dc_flag` is 1 exactly when src1 > src2 as signed 40-bit values.
- R4: After a compare with condition-select 3'b101, `dc_flag` is 1 exactly when src1 >= src2 as signed 40-bit values.
- R5: Every operation of R2 updates the status bits, whatever condition-select holds. `n_flag` is bit 39 of the 40-bit unsaturated result. `z_flag` is 1 when that value is zero. `v_flag` is 1 when the exact result lies outside the signed 32-bit range. `gt_flag` is 1 when the exact result is greater than zero.
- R6: When the exact result lies outside the signed 40-bit range (over-range), `n_flag` still shows the stored bit 39. `gt_flag`, and DC in the greater-than and greater-or-equal modes, follow the true sign of the exact result.
- R7: For add, subtract and compare, condition-select 3'b000 loads DC with the carry out of bit 39 (for subtract and compare, the borrow, 1 when src1 < src2 unsigned). Selects 3'b001, 3'b010 and 3'b011 load it with the negative, zero and overflow conditions of R5.
- R8: For add, subtract and compare, condition-select 3'b110 or 3'b111 leaves `dc_flag` unchanged, while the status bits and `result` still update.
- R9: Add-with-carry loads DC with the carry out of src1+src2+DC, and subtract-with-borrow loads it with the borrow of src1-src2-DC (1 when src1 < src2+DC unsigned), for every condition-select value.
- R10: With `sat_en` high, a written result whose exact value lies outside the signed 32-bit range is replaced by 40'h007FFFFFFF if the exact value is positive, and by 40'hFF80000000 if it is negative. With `sat_en` low the low 40 bits are written.
- R11: With `op_valid` low, or with an operation code of 3'b101, 3'b110 or 3'b111, no register changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 3 | Operation: 000 add, 001 sub, 010 compare, 011 add-carry, 100 sub-borrow |
| cond_sel | input | 3 | Condition routed into DC |
| sat_en | input | 1 | Saturate written results to 32-bit signed range |
| src1 | input | 40 | Source operand 1 (guard bits above 32-bit word) |
| src2 | input | 40 | Source operand 2 |
| result | output | 40 | Registered arithmetic result |
| dc_flag | output | 1 | Registered selected condition |
| n_flag | output | 1 | Registered negative status |
| z_flag | output | 1 | Registered zero status |
| v_flag | output | 1 | Registered 32-bit overflow status |
| gt_flag | output | 1 | Registered signed greater-than status |

## Verification
The assertions assume that `op_code`, `cond_sel`, `sat_en` and both operands are known values whenever `op_valid` is sampled high, and that inputs hold steady across each rising edge. They compare the registered flags against signed comparisons of the previous cycle's operands, so they also assume no reset in between. The bench meets these assumptions by driving every input to a defined value on the falling edge only and by keeping reset asserted through the first edges. Between operations it drops `op_valid` and never leaves an operand undriven.

// File: rtl/dsp_flag_pkg.sv
package dsp_flag_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'b000,
        OP_SUB  = 3'b001,
        OP_CMP  = 3'b010,
        OP_ADDC = 3'b011,
        OP_SUBC = 3'b100
    } alu_op_e;

    typedef enum logic [2:0] {
        SEL_CARRY = 3'b000,
        SEL_NEG   = 3'b001,
        SEL_ZERO  = 3'b010,
        SEL_OVF   = 3'b011,
        SEL_GT    = 3'b100,
        SEL_GE    = 3'b101,
        SEL_RSV6  = 3'b110,
        SEL_RSV7  = 3'b111
    } cond_sel_e;

    typedef struct packed {
        logic neg;
        logic zero;
        logic ovf;
        logic orng;
        logic gt;
        logic ge;
    } cond_bits_t;

endpackage

// File: rtl/dsp_flag_adder.sv
module dsp_flag_adder #(
    parameter int ACC_W = 40
) (
    input  logic [ACC_W-1:0] opa,
    input  logic [ACC_W-1:0] opb,
    input  logic             cin,
    input  logic             subtract,
    output logic [ACC_W+1:0] exact,
    output logic             carry
);
    localparam int EXT_W = ACC_W + 2;

    logic [EXT_W-1:0] ext_a;
    logic [EXT_W-1:0] ext_b;
    logic [ACC_W:0]   uns_sum;

    // Two extra sign bits hold any sum or difference of two signed
    // 40-bit values plus a carry without wrapping.
    assign ext_a = {{2{opa[ACC_W-1]}}, opa};
    assign ext_b = {{2{opb[ACC_W-1]}}, opb};

    always_comb begin
        if (subtract) begin
            exact   = ext_a - ext_b - EXT_W'(cin);
            uns_sum = {1'b0, opa} - {1'b0, opb} - (ACC_W+1)'(cin);
        end else begin
            exact   = ext_a + ext_b + EXT_W'(cin);
            uns_sum = {1'b0, opa} + {1'b0, opb} + (ACC_W+1)'(cin);
        end
    end

    // Bit ACC_W of the unsigned form is the carry for add, the borrow for sub.
    assign carry = uns_sum[ACC_W];

endmodule

// File: rtl/dsp_flag_cond.sv
module dsp_flag_cond
    import dsp_flag_pkg::*;
#(
    parameter int ACC_W  = 40,
    parameter int WORD_W = 32
) (
    input  logic [ACC_W+1:0] exact,
    input  logic             carry,
    input  logic             force_carry,
    input  logic [2:0]       sel,
    input  logic             dc_cur,
    output cond_bits_t       cb,
    output logic             dc_next
);
    localparam int EXT_W = ACC_W + 2;
    localparam int TOP_W = EXT_W - WORD_W + 1;

    logic [2:0]       acc_top;
    logic [TOP_W-1:0] word_top;
    cond_sel_e        sel_e;

    assign acc_top  = exact[EXT_W-1:ACC_W-1];
    assign word_top = exact[EXT_W-1:WORD_W-1];
    assign sel_e    = cond_sel_e'(sel);

    always_comb begin
        cb.neg  = exact[ACC_W-1];
        cb.zero = (exact[ACC_W-1:0] == '0);
        // Fits in N signed bits only if all bits from N-1 upward agree.
        cb.orng = !((&acc_top) || !(|acc_top));
        cb.ovf  = !((&word_top) || !(|word_top));
        // Over-range flips the stored sign; xor restores the true sign.
        cb.ge   = !(cb.neg ^ cb.orng);
        cb.gt   = !((cb.neg ^ cb.orng) || cb.zero);
    end

    always_comb begin
        dc_next = dc_cur;
        if (force_carry) begin
            dc_next = carry;
        end else begin
            unique case (sel_e)
                SEL_CARRY: dc_next = carry;
                SEL_NEG:   dc_next = cb.neg;
                SEL_ZERO:  dc_next = cb.zero;
                SEL_OVF:   dc_next = cb.ovf;
                SEL_GT:    dc_next = cb.gt;
                SEL_GE:    dc_next = cb.ge;
                SEL_RSV6,
                SEL_RSV7:  dc_next = dc_cur;
                default:   dc_next = dc_cur;
            endcase
        end
    end

endmodule

// File: rtl/dsp_flag_sat.sv
module dsp_flag_sat #(
    parameter int ACC_W       = 40,
    parameter int WORD_W      = 32,
    parameter bit SAT_SUPPORT = 1'b1
) (
    input  logic             sat_en,
    input  logic             ovf,
    input  logic             true_neg,
    input  logic [ACC_W-1:0] raw,
    output logic [ACC_W-1:0] clamped
);
    localparam logic [ACC_W-1:0] POS_LIM = ACC_W'((64'd1 << (WORD_W - 1)) - 64'd1);
    localparam logic [ACC_W-1:0] NEG_LIM = ~POS_LIM;

    generate
        if (SAT_SUPPORT) begin : g_sat
            always_comb begin
                if (sat_en && ovf) begin
                    clamped = true_neg ? NEG_LIM : POS_LIM;
                end else begin
                    clamped = raw;
                end
            end
        end else begin : g_pass
            logic unused_ok;
            assign unused_ok = sat_en ^ ovf ^ true_neg;
            assign clamped   = raw;
        end
    endgenerate

endmodule

// File: rtl/dsp_flag_unit.sv
module dsp_flag_unit
    import dsp_flag_pkg::*;
#(
    parameter int GUARD_W     = 8,
    parameter int WORD_W      = 32,
    parameter bit SAT_SUPPORT = 1'b1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        op_valid,
    input  logic [2:0]                  op_code,
    input  logic [2:0]                  cond_sel,
    input  logic                        sat_en,
    input  logic [GUARD_W+WORD_W-1:0]   src1,
    input  logic [GUARD_W+WORD_W-1:0]   src2,
    output logic [GUARD_W+WORD_W-1:0]   result,
    output logic                        dc_flag,
    output logic                        n_flag,
    output logic                        z_flag,
    output logic                        v_flag,
    output logic                        gt_flag
);
    localparam int ACC_W = GUARD_W + WORD_W;
    localparam int EXT_W = ACC_W + 2;

    alu_op_e          op;
    logic             flag_op;
    logic             wr_res;
    logic             use_sub;
    logic             carry_op;
    logic [EXT_W-1:0] exact;
    logic             carry;
    cond_bits_t       cb;
    logic             dc_next;
    logic [ACC_W-1:0] res_next;

    logic [ACC_W-1:0] result_q;
    logic             dc_q, n_q, z_q, v_q, gt_q;

    assign op = alu_op_e'(op_code);

    // Operation decode
    always_comb begin
        flag_op  = 1'b1;
        wr_res   = 1'b1;
        use_sub  = 1'b0;
        carry_op = 1'b0;
        unique case (op)
            OP_ADD:  ;
            OP_SUB:  use_sub = 1'b1;
            OP_CMP:  begin use_sub = 1'b1; wr_res = 1'b0; end
            OP_ADDC: carry_op = 1'b1;
            OP_SUBC: begin use_sub = 1'b1; carry_op = 1'b1; end
            default: begin flag_op = 1'b0; wr_res = 1'b0; end
        endcase
    end

    dsp_flag_adder #(.ACC_W(ACC_W)) u_adder (
        .opa      (src1),
        .opb      (src2),
        .cin      (carry_op & dc_q),
        .subtract (use_sub),
        .exact    (exact),
        .carry    (carry)
    );

    dsp_flag_cond #(.ACC_W(ACC_W), .WORD_W(WORD_W)) u_cond (
        .exact       (exact),
        .carry       (carry),
        .force_carry (carry_op),
        .sel         (cond_sel),
        .dc_cur      (dc_q),
        .cb          (cb),
        .dc_next     (dc_next)
    );

    dsp_flag_sat #(.ACC_W(ACC_W), .WORD_W(WORD_W), .SAT_SUPPORT(SAT_SUPPORT)) u_sat (
        .sat_en   (sat_en),
        .ovf      (cb.ovf),
        .true_neg (exact[EXT_W-1]),
        .raw      (exact[ACC_W-1:0]),
        .clamped  (res_next)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            dc_q     <= 1'b0;
            n_q      <= 1'b0;
            z_q      <= 1'b0;
            v_q      <= 1'b0;
            gt_q     <= 1'b0;
        end else if (op_valid && flag_op) begin
            dc_q <= dc_next;
            n_q  <= cb.neg;
            z_q  <= cb.zero;
            v_q  <= cb.ovf;
            gt_q <= cb.gt;
            if (wr_res) begin
                result_q <= res_next;
            end
        end
    end

    // Outputs
    always_comb begin
        result  = result_q;
        dc_flag = dc_q;
        n_flag  = n_q;
        z_flag  = z_q;
        v_flag  = v_q;
        gt_flag = gt_q;
    end

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (result_q == '0) && !dc_q && !n_q && !z_q && !v_q && !gt_q);

    assert_gt_signed_R3: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 3'b010)
        |=> gt_q == ($signed($past(src1)) > $signed($past(src2))));

    assert_ge_signed_R4: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 3'b010 && cond_sel == 3'b101)
        |=> dc_q == ($signed($past(src1)) >= $signed($past(src2))));

    assert_dc_hold_reserved_R8: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code <= 3'b010 && cond_sel[2:1] == 2'b11)
        |=> dc_q == $past(dc_q));

    assert_sat_in_range_R10: assert property (@(posedge clk) disable iff (rst)
        (op_valid && sat_en && op_code != 3'b010 && op_code <= 3'b100)
        |=> ((&result_q[ACC_W-1:WORD_W-1]) || !(|result_q[ACC_W-1:WORD_W-1])));

    assert_idle_stable_R11: assert property (@(posedge clk) disable iff (rst)
        (!op_valid || op_code > 3'b100)
        |=> $stable(result_q) && $stable(dc_q) && $stable(n_q)
            && $stable(z_q) && $stable(v_q) && $stable(gt_q));

endmodule

// File: tb/tb_dsp_flag_unit.sv
module tb_dsp_flag_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [2:0]  op_code;
    logic [2:0]  cond_sel;
    logic        sat_en;
    logic [39:0] src1, src2;
    logic [39:0] result;
    logic        dc_flag, n_flag, z_flag, v_flag, gt_flag;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [39:0] e_res;
    logic        e_dc, e_n, e_z, e_v, e_gt;

    always #5 clk = ~clk;

    dsp_flag_unit dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .cond_sel(cond_sel), .sat_en(sat_en), .src1(src1), .src2(src2),
        .result(result), .dc_flag(dc_flag), .n_flag(n_flag), .z_flag(z_flag),
        .v_flag(v_flag), .gt_flag(gt_flag)
    );

    task automatic chk(input string tag, input string what,
                       input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, "result", result, e_res);
        chk(tag, "dc", 40'(dc_flag), 40'(e_dc));
        chk(tag, "n", 40'(n_flag), 40'(e_n));
        chk(tag, "z", 40'(z_flag), 40'(e_z));
        chk(tag, "v", 40'(v_flag), 40'(e_v));
        chk(tag, "gt", 40'(gt_flag), 40'(e_gt));
    endtask

    // Issue one operation and predict its effect from the requirements.
    task automatic run_op(input string tag, input logic [2:0] op, input logic [2:0] cs,
                          input logic sat, input logic [39:0] a, input logic [39:0] b);
        longint sa, sb, tv, c;
        logic [39:0] tr;
        logic [40:0] wide;
        logic cy;
        bit is_sub, known;
        @(negedge clk);
        op_valid = 1'b1; op_code = op; cond_sel = cs; sat_en = sat; src1 = a; src2 = b;
        known  = (op <= 3'd4);
        is_sub = (op == 3'd1 || op == 3'd2 || op == 3'd4);
        c  = (op == 3'd3 || op == 3'd4) ? longint'(e_dc) : 0;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        tv = is_sub ? sa - sb - c : sa + sb + c;
        tr = tv[39:0];
        if (is_sub) cy = ({1'b0, a} < ({1'b0, b} + 41'(c)));
        else begin wide = {1'b0, a} + {1'b0, b} + 41'(c); cy = wide[40]; end
        if (known) begin
            logic v;
            v = (tv > 64'sd2147483647) || (tv < -64'sd2147483648);
            if (op != 3'd2) e_res = (sat && v) ? ((tv < 0) ? 40'hFF80000000 : 40'h007FFFFFFF) : tr;
            if (op == 3'd3 || op == 3'd4) e_dc = cy;
            else case (cs)
                3'd0: e_dc = cy;
                3'd1: e_dc = tr[39];
                3'd2: e_dc = (tr == 40'd0);
                3'd3: e_dc = v;
                3'd4: e_dc = (tv > 0);
                3'd5: e_dc = (tv >= 0);
                default: ;
            endcase
            e_n = tr[39]; e_z = (tr == 40'd0); e_v = v; e_gt = (tv > 0);
        end
        @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0;
        check_all(tag);
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        e_res = '0; e_dc = 0; e_n = 0; e_z = 0; e_v = 0; e_gt = 0;
        check_all("R1");
    endtask

    task automatic t_arith;
        run_op("R2", 3'd0, 3'd6, 1'b0, 40'h0000001234, 40'h0000000FFF);
        run_op("R2", 3'd1, 3'd6, 1'b0, 40'h0000000010, 40'h0000000020);
        run_op("R2", 3'd2, 3'd6, 1'b0, 40'h0000000005, 40'h0000000003);
    endtask

    task automatic t_gt;
        run_op("R3", 3'd2, 3'd4, 1'b0, 40'h0000000007, 40'h0000000003);
        run_op("R3", 3'd2, 3'd4, 1'b0, 40'h0000000003, 40'h0000000003);
        run_op("R3", 3'd2, 3'd4, 1'b0, 40'hFFFFFFFFFE, 40'h0000000001);
        run_op("R3", 3'd2, 3'd4, 1'b0, 40'h0000000001, 40'hFFFFFFFFFE);
    endtask

    task automatic t_ge;
        run_op("R4", 3'd2, 3'd5, 1'b0, 40'h0000000003, 40'h0000000003);
        run_op("R4", 3'd2, 3'd5, 1'b0, 40'hFFFFFFFF00, 40'h0000000000);
        run_op("R4", 3'd2, 3'd5, 1'b0, 40'h0000000100, 40'hFFFFFFFF00);
    endtask

    task automatic t_status;
        run_op("R5", 3'd0, 3'd0, 1'b0, 40'h007FFFFFFF, 40'h0000000001);
        run_op("R5", 3'd1, 3'd3, 1'b0, 40'h0000000042, 40'h0000000042);
        run_op("R5", 3'd0, 3'd2, 1'b0, 40'hFFFFFFFFF0, 40'h0000000001);
    endtask

    task automatic t_overrange;
        run_op("R6", 3'd2, 3'd4, 1'b0, 40'h7F00000000, 40'h8000000000);
        run_op("R6", 3'd2, 3'd5, 1'b0, 40'h8000000000, 40'h7F00000000);
        run_op("R6", 3'd0, 3'd4, 1'b0, 40'h8000000000, 40'h8000000000);
    endtask

    task automatic t_modes;
        run_op("R7", 3'd0, 3'd0, 1'b0, 40'hFFFFFFFFFF, 40'h0000000001);
        run_op("R7", 3'd1, 3'd0, 1'b0, 40'h0000000001, 40'h0000000002);
        run_op("R7", 3'd1, 3'd1, 1'b0, 40'h0000000001, 40'h0000000002);
        run_op("R7", 3'd1, 3'd2, 1'b0, 40'h0000000009, 40'h0000000009);
        run_op("R7", 3'd0, 3'd3, 1'b0, 40'h0070000000, 40'h0070000000);
    endtask

    task automatic t_reserved_sel;
        run_op("R8", 3'd0, 3'd2, 1'b0, 40'h0000000000, 40'h0000000000);
        run_op("R8", 3'd0, 3'd6, 1'b0, 40'h0000000003, 40'h0000000004);
        run_op("R8", 3'd2, 3'd7, 1'b0, 40'h0000000001, 40'h0000000009);
    endtask

    task automatic t_carry_chain;
        run_op("R9", 3'd0, 3'd1, 1'b0, 40'h0000000000, 40'h0000000000);
        run_op("R9", 3'd3, 3'd2, 1'b0, 40'hFFFFFFFFFF, 40'h0000000001);
        run_op("R9", 3'd3, 3'd6, 1'b0, 40'h0000000010, 40'h0000000020);
        run_op("R9", 3'd4, 3'd1, 1'b0, 40'h0000000000, 40'h0000000000);
        run_op("R9", 3'd4, 3'd5, 1'b0, 40'h0000000000, 40'h0000000000);
        run_op("R9", 3'd4, 3'd4, 1'b0, 40'h0000000005, 40'h0000000001);
    endtask

    task automatic t_sat;
        run_op("R10", 3'd0, 3'd3, 1'b1, 40'h007FFFFFFF, 40'h0000000010);
        run_op("R10", 3'd1, 3'd3, 1'b1, 40'hFF80000000, 40'h0000000001);
        run_op("R10", 3'd0, 3'd3, 1'b1, 40'h0000000100, 40'h0000000200);
        run_op("R10", 3'd0, 3'd3, 1'b0, 40'h007FFFFFFF, 40'h0000000010);
    endtask

    task automatic t_idle;
        run_op("R11", 3'd0, 3'd1, 1'b0, 40'hFFFFFFFFF0, 40'h0000000001);
        @(negedge clk);
        op_valid = 1'b0; op_code = 3'd0; cond_sel = 3'd0; sat_en = 1'b1;
        src1 = 40'h7FFFFFFFFF; src2 = 40'h7FFFFFFFFF;
        @(posedge clk);
        @(negedge clk);
        check_all("R11");
        run_op("R11", 3'd5, 3'd0, 1'b0, 40'h0000000001, 40'h0000000001);
        run_op("R11", 3'd7, 3'd2, 1'b1, 40'h7FFFFFFFFF, 40'h7FFFFFFFFF);
    endtask

    initial begin
        rst = 1'b1; op_valid = 1'b0; op_code = '0; cond_sel = '0; sat_en = 1'b0;
        src1 = '0; src2 = '0;
        e_res = '0; e_dc = 0; e_n = 0; e_z = 0; e_v = 0; e_gt = 0;
        repeat (3) @(posedge clk);
        t_reset;
        t_arith;
        t_gt;
        t_ge;
        t_status;
        t_overrange;
        t_modes;
        t_reserved_sel;
        t_carry_chain;
        t_sat;
        t_idle;
        t_reset;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule